// File: doc/BRIEF.md
# Timer Pin GPIO and Edge-Interrupt Controller

This block controls the single I/O pin of one general-purpose timer channel. Software reaches it over a simple 32-bit word-addressed register bus. A configuration word picks the pin function. In GPIO mode the pin can be driven high or low, or released so that it acts as an input. In input-capture mode the pin is watched for a chosen transition, and each detected transition sets a sticky event flag. That flag drives a single interrupt line, which is gated by an enable bit.

The pin is an asynchronous input, so its level passes through a synchroniser before anything uses it. The same synchronised level can be read back in the status word. Software acknowledges an event by writing a one to its flag bit.

The timer's counting, compare and PWM functions are not part of this block. Their function codes are stored but do not drive the pin.

Top module: `tpin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the configuration word reads 0, the status word reads 0 (with the pin held low), `irq` is 0 and `pin_oe` is 0.
- R2: Word 0 (configuration) stores the function code in bits [2:0], drive level in bit 4, drive enable in bit 5, interrupt enable in bit 8 and edge select in bits [17:16]. All other bits read back as 0.
- R3: Words 2 and 3 always read 0. Writes to them change neither the configuration nor the status word.
- R4: `pin_oe` is 1 only when the function code is 4 (GPIO) and bit 5 is 1; `pin_out` then equals bit 4. With any other code, including 1 (capture), `pin_oe` and `pin_out` are 0 regardless of bits [5:4].
- R5: Status word (word 1) bit 8 shows the pin level through a two-flop synchroniser. A change on `pin_in` becomes readable after the second rising clock edge.
- R6: With function code 1, edge select 01 captures rising edges, 10 falling edges, 11 both and 00 none. A capture sets status bit 0 on the third rising edge after the pin change, and the bit stays set until it is cleared.
- R7: With any function code other than 1, pin transitions set no flag, whatever the edge select holds.
- R8: Writing status with a one in any of bits [3:0] clears that flag on the next edge. Writing zeros leaves the flags unchanged.
- R9: When a capture and a clear of the same flag happen in the same cycle, the flag stays set.
- R10: `irq` is 1 exactly when some status flag in [3:0] is set and configuration bit 8 is 1. Clearing bit 8 masks `irq` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word index (0 configuration, 1 status, 2 and 3 read as zero) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| pin_in | input | 1 | Asynchronous level sampled from the pin |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Output driver enable (0 means the pin is released) |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults in this block show up at the ports within three clock edges. A wrong synchroniser depth moves the bit 8 change or the capture away from edge two or edge three. A stale previous-level register either raises a flag for an edge type that was not selected or misses one that was. A bad write-one-to-clear merge is visible in the very next read of the status word, and the set-versus-clear collision is exercised at that exact edge. Faults in the drive decode and the interrupt gating appear one cycle after the configuration write, on `pin_oe`, `pin_out` and `irq`.

// File: rtl/tpin_pkg.sv
// Shared field positions, codes and types for the timer pin controller.
// Assumes a bus data width of at least 18 bits, so that every field fits.
package tpin_pkg;

    localparam int CFG_FUNC_LSB  = 0;
    localparam int CFG_LVL_BIT   = 4;
    localparam int CFG_DRV_BIT   = 5;
    localparam int CFG_IEN_BIT   = 8;
    localparam int CFG_EDGE_LSB  = 16;
    localparam int STS_LEVEL_BIT = 8;

    localparam int WORD_CFG    = 0;
    localparam int WORD_STATUS = 1;

    typedef enum logic [2:0] {
        FN_IDLE    = 3'd0,
        FN_CAPTURE = 3'd1,
        FN_COMPARE = 3'd2,
        FN_PWM     = 3'd3,
        FN_GPIO    = 3'd4
    } pin_fn_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e edge_sel;
        logic      irq_en;
        logic      drv_en;
        logic      drv_lvl;
        pin_fn_e   fn;
    } cfg_t;

endpackage

// File: rtl/tpin_sync.sv
// Multi-flop synchroniser for one asynchronous input.
// Assumes STAGES >= 2. The output is reset to 0.
module tpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tpin_edge.sv
// Edge detector on an already synchronised level.
// It produces a one-cycle pulse for the selected transition type while armed.
// The previous-level register is always updated, so arming never sees a stale edge.
module tpin_edge
    import tpin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  logic      armed,
    input  edge_sel_e edge_sel,
    output logic      evt
);
    logic prev_q;
    logic rise, fall;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Classify the transition and qualify it by the selection.
    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        evt  = armed & ((rise & edge_sel[0]) | (fall & edge_sel[1]));
    end
endmodule

// File: rtl/tpin_drv.sv
// Pin driver decode. The pin is driven only in GPIO function with drive enabled.
// In every other case the pin is released and the driven level is forced to 0.
module tpin_drv
    import tpin_pkg::*;
(
    input  cfg_t cfg,
    output logic oe,
    output logic level_out
);
    // Decode the drive enable and the level.
    always_comb begin
        oe        = (cfg.fn == FN_GPIO) && cfg.drv_en;
        level_out = oe & cfg.drv_lvl;
    end
endmodule

// File: rtl/tpin_regs.sv
// Register file: configuration word, status flags with write-one-to-clear,
// and the read mux over all words. A set request wins over a clear in the same cycle.
// Words other than configuration and status read as zero and ignore writes.
module tpin_regs
    import tpin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap_evt,
    input  logic              level,
    output cfg_t              cfg,
    output logic [FLAG_W-1:0] flags,
    output logic [DATA_W-1:0] rdata
);
    localparam int NUM_WORDS = 2 ** ADDR_W;

    logic              wr_cfg, wr_sts;
    logic [FLAG_W-1:0] set_vec, clr_vec;
    logic [DATA_W-1:0] cfg_word, sts_word;
    logic [DATA_W-1:0] bank [NUM_WORDS];

    assign wr_cfg = wr && (addr == ADDR_W'(WORD_CFG));
    assign wr_sts = wr && (addr == ADDR_W'(WORD_STATUS));

    // Configuration word: keep only the defined fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_cfg) begin
            cfg.fn       <= pin_fn_e'(wdata[CFG_FUNC_LSB +: 3]);
            cfg.drv_lvl  <= wdata[CFG_LVL_BIT];
            cfg.drv_en   <= wdata[CFG_DRV_BIT];
            cfg.irq_en   <= wdata[CFG_IEN_BIT];
            cfg.edge_sel <= edge_sel_e'(wdata[CFG_EDGE_LSB +: 2]);
        end
    end

    // Build the set and clear vectors for the flags (capture feeds bit 0).
    always_comb begin
        set_vec    = '0;
        set_vec[0] = cap_evt;
        clr_vec    = wr_sts ? wdata[FLAG_W-1:0] : '0;
    end

    // Sticky flags: clear on write-one, then set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // Assemble the readable words.
    always_comb begin
        cfg_word                        = '0;
        cfg_word[CFG_FUNC_LSB +: 3]     = cfg.fn;
        cfg_word[CFG_LVL_BIT]           = cfg.drv_lvl;
        cfg_word[CFG_DRV_BIT]           = cfg.drv_en;
        cfg_word[CFG_IEN_BIT]           = cfg.irq_en;
        cfg_word[CFG_EDGE_LSB +: 2]     = cfg.edge_sel;
        sts_word                        = '0;
        sts_word[FLAG_W-1:0]            = flags;
        sts_word[STS_LEVEL_BIT]         = level;
    end

    // One bank entry per word index; unmapped words are zero.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_bank
        if (i == WORD_CFG) begin : g_cfg
            assign bank[i] = cfg_word;
        end else if (i == WORD_STATUS) begin : g_sts
            assign bank[i] = sts_word;
        end else begin : g_zero
            assign bank[i] = '0;
        end
    end

    assign rdata = bank[addr];
endmodule

// File: rtl/tpin_ctrl.sv
// Top level of the timer pin controller: synchroniser, edge detector,
// register file and pin driver. The pin input is asynchronous, the bus is
// synchronous to clk, and the reset is synchronous and active low.
module tpin_ctrl
    import tpin_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int FLAG_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);
    logic              pin_level;
    logic              cap_evt;
    cfg_t              cfg_q;
    logic [FLAG_W-1:0] flag_q;

    tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_level)
    );

    tpin_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level(pin_level),
        .armed(cfg_q.fn == FN_CAPTURE), .edge_sel(cfg_q.edge_sel), .evt(cap_evt)
    );

    tpin_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cap_evt(cap_evt), .level(pin_level), .cfg(cfg_q), .flags(flag_q),
        .rdata(bus_rdata)
    );

    tpin_drv u_drv (
        .cfg(cfg_q), .oe(pin_oe), .level_out(pin_out)
    );

    // Single interrupt line: any flag, gated by the enable.
    assign irq = (|flag_q) && cfg_q.irq_en;
endmodule

// File: rtl/tpin_ctrl_chk.sv
// Property checker for tpin_ctrl, attached by bind. It observes the bus,
// the pin outputs, the interrupt, the flags and the capture event.
module tpin_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int FLAG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              irq,
    input logic [FLAG_W-1:0] flags,
    input logic              cap_evt
);
    // R4: a GPIO drive-high configuration drives the pin high on the next cycle.
    p_drive_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[2:0] == 3'd4 && bus_wdata[5:4] == 2'b11)
        |=> (pin_oe && pin_out));

    // R4: the capture function never drives the pin.
    p_capture_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[2:0] == 3'd1) |=> !pin_oe);

    // R10: clearing the enable masks the interrupt.
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0) && !bus_wdata[8]) |=> !irq);

    // R8: a write-one clear without a concurrent capture empties flag 0.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[0] && !cap_evt) |=> !flags[0]);

    // R9: a capture always leaves flag 0 set, even under a clear.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flags[0]);

    // R6: flag 0 is sticky until a clear.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[0])) |=> flags[0]);
endmodule

bind tpin_ctrl tpin_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
    .flags(flag_q), .cap_evt(cap_evt)
);

// File: tb/tpin_ctrl_test.sv
// Directed bench for tpin_ctrl: one task per scenario, each checking its results.
module tpin_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    tpin_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pin_settle(input logic v);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); chk("R1 cfg", d, 32'h0);
        rd(2'd1, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 oe", {31'd0, pin_oe}, 32'd0);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFF7); rd(2'd0, d); chk("R2 mask", d, 32'h0003_0137);
        wr(2'd0, 32'h0002_0034); rd(2'd0, d); chk("R2 value", d, 32'h0002_0034);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_spare;
        logic [31:0] d;
        wr(2'd0, 32'h0000_0100);
        wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd2, d); chk("R3 word2", d, 32'h0);
        rd(2'd3, d); chk("R3 word3", d, 32'h0);
        rd(2'd0, d); chk("R3 cfg kept", d, 32'h0000_0100);
        rd(2'd1, d); chk("R3 status kept", d, 32'h0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_drive;
        wr(2'd0, 32'h34); chk("R4 gpio high", {30'd0, pin_oe, pin_out}, 32'd3);
        wr(2'd0, 32'h24); chk("R4 gpio low", {30'd0, pin_oe, pin_out}, 32'd2);
        wr(2'd0, 32'h14); chk("R4 released", {30'd0, pin_oe, pin_out}, 32'd0);
        wr(2'd0, 32'h31); chk("R4 capture ignores drive", {30'd0, pin_oe, pin_out}, 32'd0);
        wr(2'd0, 32'h33); chk("R4 pwm code", {30'd0, pin_oe, pin_out}, 32'd0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(2'd0, 32'h4);
        pin_in = 1'b1;
        @(posedge clk); @(negedge clk);
        rd(2'd1, d); chk("R5 one edge", d, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(2'd1, d); chk("R5 two edges", d, 32'h100);
        pin_settle(1'b0);
        rd(2'd1, d); chk("R5 back low", d, 32'h0);
    endtask

    task automatic t_capture;
        logic [31:0] d;
        wr(2'd0, 32'h0001_0001);
        pin_in = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        rd(2'd1, d); chk("R6 not yet at edge two", d, 32'h100);
        @(posedge clk); @(negedge clk);
        rd(2'd1, d); chk("R6 rising at edge three", d, 32'h101);
        wr(2'd1, 32'hF);
        pin_settle(1'b0); rd(2'd1, d); chk("R6 rise-only ignores fall", d, 32'h0);
        wr(2'd0, 32'h0002_0001);
        pin_settle(1'b1); rd(2'd1, d); chk("R6 fall-only ignores rise", d, 32'h100);
        pin_settle(1'b0); rd(2'd1, d); chk("R6 falling", d, 32'h1);
        wr(2'd1, 32'hF);
        wr(2'd0, 32'h0003_0001);
        pin_settle(1'b1); rd(2'd1, d); chk("R6 any rise", d, 32'h101);
        wr(2'd1, 32'hF);
        pin_settle(1'b0); rd(2'd1, d); chk("R6 any fall", d, 32'h1);
        wr(2'd1, 32'hF);
        wr(2'd0, 32'h0000_0001);
        pin_settle(1'b1); pin_settle(1'b0);
        rd(2'd1, d); chk("R6 no edge selected", d, 32'h0);
    endtask

    task automatic t_other_modes;
        logic [31:0] d;
        wr(2'd0, 32'h0003_0004);
        pin_settle(1'b1); pin_settle(1'b0);
        rd(2'd1, d); chk("R7 gpio no capture", d, 32'h0);
        wr(2'd0, 32'h0003_0003);
        pin_settle(1'b1); pin_settle(1'b0);
        rd(2'd1, d); chk("R7 pwm no capture", d, 32'h0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(2'd0, 32'h0001_0001);
        pin_settle(1'b1);
        wr(2'd1, 32'h0); rd(2'd1, d); chk("R8 zero write keeps", d, 32'h101);
        wr(2'd1, 32'h1); rd(2'd1, d); chk("R8 one clears", d, 32'h100);
        pin_settle(1'b0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr(2'd0, 32'h0001_0001);
        pin_in = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        wr(2'd1, 32'h1);
        rd(2'd1, d); chk("R9 set wins", d, 32'h101);
        wr(2'd1, 32'h1); rd(2'd1, d); chk("R9 later clear", d, 32'h100);
        pin_settle(1'b0);
    endtask

    task automatic t_irq;
        wr(2'd0, 32'h0001_0001);
        pin_settle(1'b1);
        chk("R10 disabled", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h0001_0101); chk("R10 enabled", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0001_0001); chk("R10 masked", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h0001_0101);
        wr(2'd1, 32'hF); chk("R10 flag cleared", {31'd0, irq}, 32'd0);
        pin_settle(1'b0);
        wr(2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_spare();
        t_drive();
        t_level();
        t_capture();
        t_other_modes();
        t_w1c();
        t_collide();
        t_irq();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule